// File: doc/BRIEF.md
# IDE Command Block Decoder

This block sits behind the host I/O decode of a two-channel IDE controller. Each host access arrives already reduced to an offset into a 40-byte internal register file. The file holds the command window and the control window of each channel, followed by a bus-master area. The block checks that the access width suits the register it lands on. Plain registers are stored and read back byte for byte, little-endian, and every result appears one clock after the request.

A byte written to either channel's command register is treated as a new command for one of four drives. The drive index is formed from the channel and the drive-select bit that software left in that channel's select register. The block keeps a busy flag for each drive. It refuses a command for a drive that is absent or still busy. An accepted command is copied into the alternate-status byte and announced on a one-cycle strobe that carries the drive index and the command byte. The drive side ends a command by pulsing a done input with the drive index, which clears that drive's busy flag. A single enable input switches the whole I/O space off.

Top module: `ide_cmd_decoder`

## Requirements
- R1: After reset every register-file byte reads as zero, all four busy flags are clear, and no strobe or error output is high.
- R2: With the I/O space enabled, a write with size code 0, 1 or 2 (1, 2 or 4 bytes) stores data byte k (bits 8k+7:8k) at offset addr+k. A read returns byte addr+k in the same lane, with rdValid high for exactly the cycle after the request. Bytes at offset 40 or above are dropped on writes and read as zero.
- R3: Size code 3 is invalid: sizeErr pulses one cycle later, nothing is stored, and no read response is given.
- R4: The data ports at offsets 0x00 and 0x0C accept only size code 1. Any other width raises sizeErr and changes nothing.
- R5: The command registers at offsets 0x07 (channel 0) and 0x13 (channel 1) accept only size code 0. Any other width raises sizeErr and has no further effect.
- R6: A command write addresses drive 2*channel + s, where s is bit 4 of the select byte of that channel (offset 0x06 for channel 0, offset 0x12 for channel 1).
- R7: A command write to a present, idle drive stores the byte at the command offset and at the offset 3 above it (0x0A or 0x16). One cycle later issueValid pulses for one cycle with issueDrive and issueCmd, and that drive's busy flag is set.
- R8: A command write to a busy drive pulses busyErr, issues nothing, and leaves the register file unchanged.
- R9: A command write to a drive whose drivePresent bit is 0 pulses absentErr, issues nothing, leaves the register file unchanged and leaves the busy flag clear.
- R10: A doneValid pulse clears the busy flag of drive doneDrive on the next clock. A command accepted for the same drive in the same cycle takes priority and sets the flag.
- R11: While ioEnable is low, every request is ignored: no store, no read response, no error and no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioEnable | input | 1 | I/O space enable |
| reqValid | input | 1 | Host access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Register-file byte offset |
| reqSize | input | 2 | 0 = byte, 1 = 16 bit, 2 = 32 bit, 3 = invalid |
| reqWdata | input | 32 | Write data, byte k in bits 8k+7:8k |
| drivePresent | input | 4 | One bit per drive, 1 = present |
| doneValid | input | 1 | Command-complete pulse from the drive side |
| doneDrive | input | 2 | Drive index of the completing command |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| sizeErr | output | 1 | Width or size-code error pulse |
| busyErr | output | 1 | Command refused, drive busy |
| absentErr | output | 1 | Command refused, drive absent |
| issueValid | output | 1 | Command-issue strobe |
| issueDrive | output | 2 | Drive index of the issued command |
| issueCmd | output | 8 | Issued command byte |
| driveBusy | output | 4 | Per-drive busy flags |

## Verification
The bench checks the drive index taken from the select bit on the channel-1 side. A design that read the wrong register or bit would start the wrong drive, and the busy flags would diverge. It sends a second command to a busy drive and a command to an absent drive. Reissuing or latching a refused command would show up as a spurious strobe or a changed command byte. It also tests a done pulse in the same cycle as a command for the same drive, where the wrong priority loses the busy flag. The remaining cases are wrong-width accesses to the data and command ports, reads that run past the end of the file, and traffic while the I/O space is disabled. Any leak there alters a later readback.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int NUM_DRV    = 4;
  localparam int DRV_W      = $clog2(NUM_DRV);
  localparam int ALT_GAP    = 3;
  localparam int SEL_BIT    = 4;

  // Command-window layout; the decoder depends on these offsets.
  localparam logic [ADDR_W-1:0] CH0_DATA = 6'h00;
  localparam logic [ADDR_W-1:0] CH0_SEL  = 6'h06;
  localparam logic [ADDR_W-1:0] CH0_CMD  = 6'h07;
  localparam logic [ADDR_W-1:0] CH1_DATA = 6'h0C;
  localparam logic [ADDR_W-1:0] CH1_SEL  = 6'h12;
  localparam logic [ADDR_W-1:0] CH1_CMD  = 6'h13;

  typedef enum logic [1:0] {SZ_B8 = 2'd0, SZ_B16 = 2'd1, SZ_B32 = 2'd2, SZ_RSVD = 2'd3} accSize_e;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [1:0]        wrSize;
    logic [DATA_W-1:0] wrData;
    logic              mirEn;
    logic [ADDR_W-1:0] mirAddr;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
    logic [1:0]        rdSize;
  } regStb_t;

  function automatic int sizeBytes(logic [1:0] s);
    case (s)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ide_dec_regs.sv
module ide_dec_regs
  import ide_dec_pkg::*;
#(
  parameter int REG_BYTES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        selBits
);
  logic [7:0] regFile [REG_BYTES];
  logic [7:0] byteVal [REG_BYTES];
  logic [REG_BYTES-1:0] byteEn;
  logic [DATA_W-1:0] rdNext;

  // Lane steering: which file bytes a write touches, and with what value.
  always_comb begin
    byteEn = '0;
    for (int i = 0; i < REG_BYTES; i++) byteVal[i] = 8'h00;
    if (stb.wrEn) begin
      for (int k = 0; k < DATA_BYTES; k++) begin
        if (k < sizeBytes(stb.wrSize) && int'(stb.wrAddr) + k < REG_BYTES) begin
          byteEn[int'(stb.wrAddr) + k]  = 1'b1;
          byteVal[int'(stb.wrAddr) + k] = stb.wrData[8*k +: 8];
        end
      end
    end
    if (stb.mirEn && int'(stb.mirAddr) < REG_BYTES) begin
      byteEn[int'(stb.mirAddr)]  = 1'b1;
      byteVal[int'(stb.mirAddr)] = stb.wrData[7:0];
    end
  end

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (k < sizeBytes(stb.rdSize) && int'(stb.rdAddr) + k < REG_BYTES)
        rdNext[8*k +: 8] = regFile[int'(stb.rdAddr) + k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_BYTES; i++) regFile[i] <= 8'h00;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      for (int i = 0; i < REG_BYTES; i++)
        if (byteEn[i]) regFile[i] <= byteVal[i];
      rdValid <= stb.rdEn;
      rdData  <= stb.rdEn ? rdNext : '0;
    end
  end

  assign selBits = {regFile[int'(CH1_SEL)][SEL_BIT], regFile[int'(CH0_SEL)][SEL_BIT]};

  // Alternate-status copy must equal the command byte after acceptance.
  logic [ADDR_W-1:0] mirAddrQ;
  always_ff @(posedge clk) mirAddrQ <= stb.mirAddr;

  assert_alt_mirror_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.mirEn |=> regFile[int'(mirAddrQ)] == regFile[int'(mirAddrQ) - ALT_GAP]);
endmodule

// File: rtl/ide_dec_ctrl.sv
module ide_dec_ctrl
  import ide_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioEnable,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqSize,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [NUM_DRV-1:0] drivePresent,
  input  logic               doneValid,
  input  logic [DRV_W-1:0]   doneDrive,
  input  logic [1:0]         selBits,
  output regStb_t            stb,
  output logic               sizeErr,
  output logic               busyErr,
  output logic               absentErr,
  output logic               issueValid,
  output logic [DRV_W-1:0]   issueDrive,
  output logic [7:0]         issueCmd,
  output logic [NUM_DRV-1:0] driveBusy
);
  logic active, isData, isCmd, chSel, badSize, cmdWr, drvAbsent, drvBusy, goCmd;
  logic [DRV_W-1:0] drvIdx;

  always_comb begin
    active    = reqValid && ioEnable;
    isData    = (reqAddr == CH0_DATA) || (reqAddr == CH1_DATA);
    isCmd     = (reqAddr == CH0_CMD)  || (reqAddr == CH1_CMD);
    chSel     = (reqAddr == CH1_CMD);
    drvIdx    = {chSel, selBits[chSel]};
    badSize   = (reqSize == SZ_RSVD) || (isData && reqSize != SZ_B16) ||
                (isCmd && reqSize != SZ_B8);
    cmdWr     = active && reqWrite && isCmd && !badSize;
    drvAbsent = !drivePresent[drvIdx];
    drvBusy   = driveBusy[drvIdx];
    goCmd     = cmdWr && !drvAbsent && !drvBusy;

    stb.wrEn    = active && reqWrite && !badSize && (!isCmd || goCmd);
    stb.wrAddr  = reqAddr;
    stb.wrSize  = reqSize;
    stb.wrData  = reqWdata;
    stb.mirEn   = goCmd;
    stb.mirAddr = reqAddr + ADDR_W'(ALT_GAP);
    stb.rdEn    = active && !reqWrite && !badSize;
    stb.rdAddr  = reqAddr;
    stb.rdSize  = reqSize;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeErr    <= 1'b0;
      busyErr    <= 1'b0;
      absentErr  <= 1'b0;
      issueValid <= 1'b0;
      issueDrive <= '0;
      issueCmd   <= 8'h00;
      driveBusy  <= '0;
    end else begin
      sizeErr    <= active && badSize;
      busyErr    <= cmdWr && !drvAbsent && drvBusy;
      absentErr  <= cmdWr && drvAbsent;
      issueValid <= goCmd;
      issueDrive <= drvIdx;
      issueCmd   <= reqWdata[7:0];
      for (int d = 0; d < NUM_DRV; d++) begin
        if (goCmd && drvIdx == DRV_W'(d))                driveBusy[d] <= 1'b1;
        else if (doneValid && doneDrive == DRV_W'(d))    driveBusy[d] <= 1'b0;
      end
    end
  end

  assert_busy_on_issue_R7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> driveBusy[issueDrive]);

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sizeErr, busyErr, absentErr, issueValid}));

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ioEnable |=> !(sizeErr || busyErr || absentErr || issueValid));

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_busyChk
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(driveBusy[d]) |-> issueValid && issueDrive == DRV_W'(d));
    assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
      $fell(driveBusy[d]) |-> $past(doneValid) && $past(doneDrive) == DRV_W'(d));
  end
endmodule

// File: rtl/ide_cmd_decoder.sv
module ide_cmd_decoder
  import ide_dec_pkg::*;
#(
  parameter int REG_BYTES = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ioEnable,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic [5:0]   reqAddr,
  input  logic [1:0]   reqSize,
  input  logic [31:0]  reqWdata,
  input  logic [3:0]   drivePresent,
  input  logic         doneValid,
  input  logic [1:0]   doneDrive,
  output logic         rdValid,
  output logic [31:0]  rdData,
  output logic         sizeErr,
  output logic         busyErr,
  output logic         absentErr,
  output logic         issueValid,
  output logic [1:0]   issueDrive,
  output logic [7:0]   issueCmd,
  output logic [3:0]   driveBusy
);
  regStb_t    stb;
  logic [1:0] selBits;

  ide_dec_ctrl i_ctrl (
    .clk, .rstN, .ioEnable, .reqValid, .reqWrite, .reqAddr, .reqSize, .reqWdata,
    .drivePresent, .doneValid, .doneDrive, .selBits, .stb,
    .sizeErr, .busyErr, .absentErr, .issueValid, .issueDrive, .issueCmd, .driveBusy
  );

  ide_dec_regs #(.REG_BYTES(REG_BYTES)) i_regs (
    .clk, .rstN, .stb, .rdValid, .rdData, .selBits
  );
endmodule

// File: tb/test_ide_cmd_decoder.sv
`timescale 1ns/1ps
module test_ide_cmd_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioEnable = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [5:0]  reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  drivePresent = '0;
  logic        doneValid = 1'b0;
  logic [1:0]  doneDrive = '0;
  logic        rdValid, sizeErr, busyErr, absentErr, issueValid;
  logic [31:0] rdData;
  logic [1:0]  issueDrive;
  logic [7:0]  issueCmd;
  logic [3:0]  driveBusy;

  ide_cmd_decoder i_ide_cmd_decoder (.*);

  always #10 clk = ~clk;

  int  checks = 0, fails = 0;
  bit  finished = 1'b0;
  logic [7:0] mdl [40];
  logic [3:0] mBusy;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int nbOf(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
  endfunction

  // One request (optionally with a done pulse); entered and left at a negedge.
  task automatic access(input string tag, input bit wr, input logic [5:0] a,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input bit dv = 1'b0, input logic [1:0] dd = 2'd0);
    bit isD, isC, bad, eRdV = 0, eSz = 0, eBsy = 0, eAbs = 0, eIss = 0;
    logic [31:0] eRd = '0;
    logic [1:0]  eDrv = '0;
    int nb = nbOf(sz);
    isD = (a == 6'h00) || (a == 6'h0C);
    isC = (a == 6'h07) || (a == 6'h13);
    bad = (sz == 2'd3) || (isD && sz != 2'd1) || (isC && sz != 2'd0);
    if (ioEnable) begin
      if (bad) eSz = 1;
      else if (wr && isC) begin
        eDrv = (a == 6'h13) ? {1'b1, mdl[18][4]} : {1'b0, mdl[6][4]};
        if (!drivePresent[eDrv]) eAbs = 1;
        else if (mBusy[eDrv]) eBsy = 1;
        else begin
          eIss = 1; mdl[a] = wd[7:0]; mdl[a + 3] = wd[7:0];
        end
      end else if (wr) begin
        for (int k = 0; k < nb; k++) if (int'(a) + k < 40) mdl[int'(a) + k] = wd[8*k +: 8];
      end else begin
        eRdV = 1;
        for (int k = 0; k < nb; k++) if (int'(a) + k < 40) eRd[8*k +: 8] = mdl[int'(a) + k];
      end
    end
    if (dv && !(eIss && eDrv == dd)) mBusy[dd] = 1'b0;
    if (eIss) mBusy[eDrv] = 1'b1;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    doneValid = dv; doneDrive = dd;
    @(negedge clk);
    reqValid = 0; doneValid = 0;
    chk({tag, " rdValid"}, 32'(rdValid), 32'(eRdV));
    if (eRdV) chk({tag, " rdData"}, rdData, eRd);
    chk({tag, " sizeErr"}, 32'(sizeErr), 32'(eSz));
    chk({tag, " busyErr"}, 32'(busyErr), 32'(eBsy));
    chk({tag, " absentErr"}, 32'(absentErr), 32'(eAbs));
    chk({tag, " issueValid"}, 32'(issueValid), 32'(eIss));
    if (eIss) begin
      chk({tag, " issueDrive"}, 32'(issueDrive), 32'(eDrv));
      chk({tag, " issueCmd"}, 32'(issueCmd), 32'(wd[7:0]));
    end
    chk({tag, " driveBusy"}, 32'(driveBusy), 32'(mBusy));
  endtask

  task automatic pulseDone(input string tag, input logic [1:0] d);
    doneValid = 1; doneDrive = d;
    @(negedge clk);
    doneValid = 0;
    mBusy[d] = 1'b0;
    chk({tag, " driveBusy"}, 32'(driveBusy), 32'(mBusy));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 40; i++) mdl[i] = 8'h00;
    mBusy = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 driveBusy", 32'(driveBusy), 32'h0);
    chk("R1 issueValid", 32'(issueValid), 32'h0);
    chk("R1 sizeErr", 32'(sizeErr), 32'h0);
    ioEnable = 1'b1;
    for (int a = 4; a < 40; a += 4) access("R1 zero", 1'b0, 6'(a), 2'd2, 32'h0);

    // R2: widths, lanes, end of file
    access("R2 wr32", 1'b1, 6'h18, 2'd2, 32'h44332211);
    access("R2 rd8", 1'b0, 6'h19, 2'd0, 32'h0);
    access("R2 rd16", 1'b0, 6'h1A, 2'd1, 32'h0);
    access("R2 rd32", 1'b0, 6'h18, 2'd2, 32'h0);
    access("R2 wrEnd", 1'b1, 6'h26, 2'd2, 32'hDDCCBBAA);
    access("R2 rdEnd", 1'b0, 6'h25, 2'd2, 32'h0);
    // R3: reserved size code
    access("R3 bad", 1'b1, 6'h18, 2'd3, 32'hFFFFFFFF);
    access("R3 keep", 1'b0, 6'h18, 2'd2, 32'h0);
    // R4: data port width
    access("R4 byte", 1'b1, 6'h0C, 2'd0, 32'h5A);
    access("R4 half", 1'b1, 6'h0C, 2'd1, 32'hBEEF);
    access("R4 rd", 1'b0, 6'h0C, 2'd1, 32'h0);
    access("R4 rdBad", 1'b0, 6'h00, 2'd2, 32'h0);
    // R5: command register width
    access("R5 half", 1'b1, 6'h13, 2'd1, 32'h00EC);
    // R6/R7: drive 3 via channel 1 select bit
    drivePresent = 4'b1111;
    access("R6 sel", 1'b1, 6'h12, 2'd0, 32'h10);
    access("R6 R7 cmd", 1'b1, 6'h13, 2'd0, 32'hEC);
    access("R7 alt", 1'b0, 6'h16, 2'd0, 32'h0);
    // R8: busy refusal
    access("R8 busy", 1'b1, 6'h13, 2'd0, 32'h20);
    access("R8 keep", 1'b0, 6'h13, 2'd0, 32'h0);
    // R10: done clears
    pulseDone("R10 done", 2'd3);
    // R10: same-cycle done and command for drive 2
    access("R10 sel", 1'b1, 6'h12, 2'd0, 32'h00);
    access("R10 race", 1'b1, 6'h13, 2'd0, 32'hC8, 1'b1, 2'd2);
    pulseDone("R10 done2", 2'd2);
    // R9: absent drive 1
    drivePresent = 4'b0001;
    access("R9 sel", 1'b1, 6'h06, 2'd0, 32'h10);
    access("R9 absent", 1'b1, 6'h07, 2'd0, 32'h30);
    access("R9 keep", 1'b0, 6'h07, 2'd0, 32'h0);
    // R11: disabled
    ioEnable = 1'b0;
    access("R11 wr", 1'b1, 6'h18, 2'd0, 32'hAA);
    access("R11 rd", 1'b0, 6'h18, 2'd0, 32'h0);
    access("R11 bad", 1'b1, 6'h07, 2'd2, 32'h0);
    ioEnable = 1'b1;
    access("R11 keep", 1'b0, 6'h18, 2'd0, 32'h0);

    // Random mix covering R2 R4 R5 R6 R7 R8 R9 R10 R11
    for (int n = 0; n < 1500; n++) begin
      logic [5:0] a;
      logic [1:0] sz;
      bit wr;
      ioEnable = ($urandom % 10) != 0;
      if ($urandom % 16 == 0) drivePresent = 4'($urandom);
      case ($urandom % 8)
        0: a = 6'h07; 1: a = 6'h13; 2: a = 6'h06; 3: a = 6'h12;
        default: a = 6'($urandom % 44);
      endcase
      wr = ($urandom % 2) == 1;
      if ($urandom % 6 == 0) sz = 2'($urandom);
      else if (a == 6'h07 || a == 6'h13) sz = 2'd0;
      else if (a == 6'h00 || a == 6'h0C) sz = 2'd1;
      else sz = 2'($urandom % 3);
      access("R2 R7 R8 R9 R10 rand", wr, a, sz, $urandom, ($urandom % 4) == 0, 2'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule